// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with Result Interlock

This block is the multiply/divide unit of a 32-bit scalar integer core. It takes an operation code and two 32-bit operands, forms either a 64-bit product or a quotient/remainder pair, and places the result in a pair of result registers, HI and LO. A multiply leaves the low half of the product in LO and the high half in HI. A divide leaves the quotient in LO and the remainder in HI. Two further operations load HI or LO straight from the first operand.

Each arithmetic operation runs for a modelled latency. A divide always takes a fixed number of cycles. A multiply takes a short, medium or long latency, chosen by the magnitude of its first operand. While this countdown runs, the unit reports itself busy and the result registers keep their previous contents. The new result appears on the edge where the countdown ends. A pipeline that wants to read HI or LO raises a read request. The unit answers with a stall for as long as it is busy, so the read completes on the first cycle that the new result is visible. Division by zero and the one signed overflow case give fixed, defined results and raise no trap.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, HI and LO read 0, and busy and stall are low.
- R2: Operation code 0 (signed multiply) forms the 64-bit two's complement product of opA and opB. It delivers bits 31:0 on LO and bits 63:32 on HI.
- R3: Operation code 1 (unsigned multiply) forms the 64-bit product of opA and opB taken as unsigned values, with the same split as R2.
- R4: An unsigned multiply is busy for 7 + 4*(2 - floor(z/11)) cycles, where z is the count of leading zeros of (opA OR 1). This gives 15, 11 or 7 cycles.
- R5: A signed multiply uses the latency rule of R4 with z taken from ((opA XOR (opA arithmetically shifted right by 21)) OR 1).
- R6: Operation code 2 (signed divide) is busy for 37 cycles. It gives the quotient truncated toward zero on LO, and on HI a remainder whose sign follows the dividend.
- R7: Operation code 3 (unsigned divide) is busy for 37 cycles and gives the unsigned quotient on LO and the unsigned remainder on HI.
- R8: A divide by zero puts the dividend on HI. LO becomes 0xFFFFFFFF, except for a signed divide with a negative dividend, where LO becomes 1.
- R9: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R10: stall is high exactly while readReq is high and the unit is busy.
- R11: While busy, HI and LO keep their previous values. The new result appears on the same clock edge where busy falls.
- R12: Operation codes 4 and 5 copy opA into HI or LO on the next edge, even while busy, and leave busy unchanged. A half written this way is not overwritten when a pending result completes.
- R13: An arithmetic operation issued while busy restarts the countdown with its own latency, and the earlier pending result is discarded. Operation codes 6 and 7, and any cycle with opValid low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Issues opCode this cycle |
| opCode | input | 3 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div, 4 write HI, 5 write LO |
| opA | input | 32 | First operand (multiplicand, dividend, or data for a direct write) |
| opB | input | 32 | Second operand (multiplier or divisor) |
| readReq | input | 1 | Pipeline wants to read HI or LO this cycle |
| hiOut | output | 32 | HI register |
| loOut | output | 32 | LO register |
| busy | output | 1 | Countdown of an arithmetic operation is running |
| stall | output | 1 | Read request must wait |

## Verification
A wrong countdown value is visible at the ports as a busy pulse of the wrong length. The bench measures the length of that pulse for every operation, so a latency error shows within at most 37 cycles of the issue. A corrupted pending result, or a wrong commit ordering against a direct write, shows up as a wrong value on HI or LO on the first cycle after busy falls. A result that commits early shows up as HI changing while busy is still high, which is checked on the cycle right after issue.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_DIV_S  = 3'd2,
    OP_DIV_U  = 3'd3,
    OP_WR_HI  = 3'd4,
    OP_WR_LO  = 3'd5
  } mduOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPend;  // capture a freshly computed result
    logic commit;    // move pending result into HI/LO
    logic wrHi;      // direct write of HI
    logic wrLo;      // direct write of LO
  } mduStrobe_t;

endpackage

// File: rtl/mdu_control.sv
module mdu_control
  import mdu_pkg::*;
#(
  parameter int W          = 32,
  parameter int DIV_CYCLES = 37,
  parameter int MUL_BASE   = 7,
  parameter int MUL_STEP   = 4,
  parameter int MUL_GROUP  = 11,
  parameter int MUL_TIERS  = 3,
  parameter int SIGN_SHIFT = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         opValid,
  input  logic [2:0]   opCode,
  input  logic [W-1:0] opA,
  output mduStrobe_t   strobe,
  output logic         busy
);
  localparam int MAX_LAT = (DIV_CYCLES > MUL_BASE + (MUL_TIERS - 1) * MUL_STEP)
                           ? DIV_CYCLES : MUL_BASE + (MUL_TIERS - 1) * MUL_STEP;
  localparam int CW = $clog2(MAX_LAT + 1);
  localparam int ZW = $clog2(W + 1);

  logic [CW-1:0] count;
  logic [CW-1:0] latency;
  logic [W-1:0]  magVal;
  logic [ZW-1:0] leadZeros;
  logic          issue;
  logic          isDiv;

  assign issue = opValid && (opCode <= 3'd3);
  assign isDiv = (opCode == OP_DIV_S) || (opCode == OP_DIV_U);

  // value whose leading zeros pick the multiply tier
  always_comb begin
    if (opCode == OP_MUL_S)
      magVal = (opA ^ W'($signed(opA) >>> SIGN_SHIFT)) | W'(1);
    else
      magVal = opA | W'(1);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    leadZeros = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (magVal[i]) found = 1'b1;
        else leadZeros = leadZeros + ZW'(1);
      end
    end
  end

  always_comb begin
    int tier;
    tier = int'(leadZeros) / MUL_GROUP;
    if (tier > MUL_TIERS - 1) tier = MUL_TIERS - 1;
    if (isDiv) latency = CW'(DIV_CYCLES);
    else       latency = CW'(MUL_BASE + (MUL_TIERS - 1 - tier) * MUL_STEP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (issue)      count <= latency;
    else if (count != 0) count <= count - CW'(1);
  end

  assign busy            = (count != '0);
  assign strobe.loadPend = issue;
  assign strobe.commit   = (count == CW'(1)) && !issue;
  assign strobe.wrHi     = opValid && (opCode == OP_WR_HI);
  assign strobe.wrLo     = opValid && (opCode == OP_WR_LO);
endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mduStrobe_t   strobe,
  input  logic [2:0]   opCode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);
  localparam int PW = 2 * W + 2;

  logic          sgn;
  logic          isDiv;
  logic [PW-1:0] product;
  logic [W-1:0]  magA, magB, uQuot, uRem;
  logic [W-1:0]  resHi, resLo;
  logic [W-1:0]  pendHi, pendLo, hiQ, loQ;

  assign sgn   = (opCode == OP_MUL_S) || (opCode == OP_DIV_S);
  assign isDiv = (opCode == OP_DIV_S) || (opCode == OP_DIV_U);

  // one W+1 bit signed multiplier serves both signednesses
  assign product = PW'($signed({sgn & opA[W-1], opA}) * $signed({sgn & opB[W-1], opB}));

  // one unsigned divider with sign fix-up
  assign magA  = (sgn && opA[W-1]) ? -opA : opA;
  assign magB  = (sgn && opB[W-1]) ? -opB : opB;
  assign uQuot = (magB == '0) ? '0 : magA / magB;
  assign uRem  = (magB == '0) ? '0 : magA % magB;

  always_comb begin
    if (!isDiv) begin
      resLo = product[W-1:0];
      resHi = product[2*W-1:W];
    end else if (opB == '0) begin
      resHi = opA;
      resLo = (sgn && opA[W-1]) ? W'(1) : '1;
    end else begin
      resLo = (sgn && (opA[W-1] ^ opB[W-1])) ? -uQuot : uQuot;
      resHi = (sgn && opA[W-1]) ? -uRem : uRem;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendHi <= '0;
      pendLo <= '0;
      hiQ    <= '0;
      loQ    <= '0;
    end else begin
      if (strobe.loadPend) begin
        pendHi <= resHi;
        pendLo <= resLo;
      end
      if (strobe.commit) begin
        hiQ <= pendHi;
        loQ <= pendLo;
      end
      if (strobe.wrHi) begin
        hiQ    <= opA;
        pendHi <= opA;
      end
      if (strobe.wrLo) begin
        loQ    <= opA;
        pendLo <= opA;
      end
    end
  end

  assign hiOut = hiQ;
  assign loOut = loQ;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int W          = 32,
  parameter int DIV_CYCLES = 37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         opValid,
  input  logic [2:0]   opCode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         readReq,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut,
  output logic         busy,
  output logic         stall
);
  mduStrobe_t strobe;

  mdu_control #(.W(W), .DIV_CYCLES(DIV_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .opA(opA), .strobe(strobe), .busy(busy)
  );

  mdu_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opCode(opCode),
    .opA(opA), .opB(opB), .hiOut(hiOut), .loOut(loOut)
  );

  assign stall = readReq & busy;
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W          = 32,
  parameter int DIV_CYCLES = 37
) (
  input logic         clk,
  input logic         rst_n,
  input logic         opValid,
  input logic [2:0]   opCode,
  input logic [W-1:0] opA,
  input logic         readReq,
  input logic [W-1:0] hiOut,
  input logic [W-1:0] loOut,
  input logic         busy,
  input logic         stall
);
  logic [7:0] busyRun;
  logic       arithIssue;
  assign arithIssue = opValid && (opCode <= 3'd3);

  always_ff @(posedge clk) begin
    if (!rst_n)          busyRun <= '0;
    else if (arithIssue) busyRun <= '0;
    else if (busy)       busyRun <= busyRun + 8'd1;
  end

  // R10
  stall_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readReq && busy) |-> stall);

  // R10
  no_stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stall);

  // R11
  hi_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(opValid && opCode == 3'd4)) |=> (!busy || $stable(hiOut)));

  // R11
  lo_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(opValid && opCode == 3'd5)) |=> (!busy || $stable(loOut)));

  // R12
  lo_direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode == 3'd5) |=> (loOut == $past(opA)));

  // R6
  div_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (opCode == 3'd2 || opCode == 3'd3)) |=> busy);

  // R6
  busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busyRun <= 8'(DIV_CYCLES));
endmodule

bind muldiv_unit mdu_checker #(.W(W), .DIV_CYCLES(DIV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode), .opA(opA),
  .readReq(readReq), .hiOut(hiOut), .loOut(loOut), .busy(busy), .stall(stall)
);

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [31:0] opA = 32'd0, opB = 32'd0;
  logic        readReq = 1'b0;
  logic [31:0] hiOut, loOut;
  logic        busy, stall;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  muldiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .readReq(readReq), .hiOut(hiOut), .loOut(loOut),
    .busy(busy), .stall(stall)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clz(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return 31 - i;
    return 32;
  endfunction

  function automatic int expLat(input logic [2:0] op, input logic [31:0] a);
    logic [31:0] v;
    if (op == 3'd2 || op == 3'd3) return 37;
    if (op == 3'd0) v = (a ^ 32'($signed(a) >>> 21)) | 32'd1;
    else            v = a | 32'd1;
    return 7 + (2 - clz(v) / 11) * 4;
  endfunction

  function automatic logic [63:0] expRes(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      3'd0: begin p = 64'(sa * sb); return p; end
      3'd1: begin p = {32'd0, a} * {32'd0, b}; return p; end
      3'd2: begin
        if (b == 0) return {a, (a[31] ? 32'd1 : 32'hFFFFFFFF)};
        q = sa / sb; r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFFFFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  // issue one arithmetic op, measure busy length and result
  task automatic runOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
    logic [31:0] oldHi, oldLo;
    logic [63:0] e;
    int n;
    int lat;
    e = expRes(op, a, b);
    lat = expLat(op, a);
    oldHi = hiOut; oldLo = loOut;
    @(negedge clk);
    opValid = 1'b1; opCode = op; opA = a; opB = b; readReq = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    chk(stall == 1'b1, "R10 stall while busy", 32'(stall), 32'd1);
    chk(hiOut == oldHi && loOut == oldLo, "R11 held while busy", hiOut, oldHi);
    n = busy ? 1 : 0;
    while (busy && n < 64) begin
      @(negedge clk);
      if (busy) n++;
    end
    chk(n == lat, {req, " latency"}, 32'(n), 32'(lat));
    chk(loOut == e[31:0], {req, " LO"}, loOut, e[31:0]);
    chk(hiOut == e[63:32], {req, " HI"}, hiOut, e[63:32]);
    chk(stall == 1'b0, "R10 no stall idle", 32'(stall), 32'd0);
    readReq = 1'b0;
  endtask

  initial begin
    logic [63:0] e;
    logic [2:0]  rop;
    logic [31:0] ra, rb;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(hiOut == 0 && loOut == 0, "R1 reset HI/LO", hiOut, 32'd0);
    chk(busy == 0 && stall == 0, "R1 reset busy", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed multiply cases
    runOp(3'd0, 32'hFFFF_FFFD, 32'h0000_0007, "R2 signed mul");
    runOp(3'd0, 32'h8000_0000, 32'h8000_0000, "R5 signed mul long");
    runOp(3'd0, 32'h0012_3456, 32'hFFFF_0001, "R5 signed mul mid");
    runOp(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 unsigned mul");
    runOp(3'd1, 32'h8000_0000, 32'd3, "R4 unsigned mul 15");
    runOp(3'd1, 32'h0010_0000, 32'd3, "R4 unsigned mul 11");
    runOp(3'd1, 32'h0000_0003, 32'd5, "R4 unsigned mul 7");
    // directed divide cases
    runOp(3'd2, 32'hFFFF_FFF9, 32'd2, "R6 signed div");
    runOp(3'd2, 32'd7, 32'hFFFF_FFFE, "R6 signed div neg divisor");
    runOp(3'd3, 32'hFFFF_FFF9, 32'd2, "R7 unsigned div");
    runOp(3'd2, 32'hFFFF_FF00, 32'd0, "R8 signed div zero neg");
    runOp(3'd2, 32'd1234, 32'd0, "R8 signed div zero pos");
    runOp(3'd3, 32'h8765_4321, 32'd0, "R8 unsigned div zero");
    runOp(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R9 signed overflow");

    // R12 direct writes while a divide is pending
    e = expRes(3'd3, 32'd1000, 32'd7);
    @(negedge clk); opValid = 1; opCode = 3'd3; opA = 32'd1000; opB = 32'd7;
    @(negedge clk); opCode = 3'd4; opA = 32'hCAFE_0001;
    @(negedge clk); opValid = 0;
    chk(hiOut == 32'hCAFE_0001, "R12 HI direct write", hiOut, 32'hCAFE_0001);
    chk(busy == 1'b1, "R12 busy kept", 32'(busy), 32'd1);
    while (busy) @(negedge clk);
    chk(hiOut == 32'hCAFE_0001, "R12 HI not overwritten", hiOut, 32'hCAFE_0001);
    chk(loOut == e[31:0], "R12 LO from divide", loOut, e[31:0]);
    @(negedge clk); opValid = 1; opCode = 3'd5; opA = 32'h1357_9BDF;
    @(negedge clk); opValid = 0;
    chk(loOut == 32'h1357_9BDF, "R12 LO direct write", loOut, 32'h1357_9BDF);
    chk(busy == 1'b0, "R12 idle after write", 32'(busy), 32'd0);

    // R13 ignored codes and opValid low
    @(negedge clk); opValid = 1; opCode = 3'd6; opA = 32'hDEAD_BEEF; opB = 32'd1;
    @(negedge clk); opCode = 3'd7;
    @(negedge clk); opValid = 0; opCode = 3'd4;
    @(negedge clk);
    chk(hiOut == 32'hCAFE_0001 && busy == 0, "R13 ignored code HI", hiOut, 32'hCAFE_0001);
    chk(loOut == 32'h1357_9BDF, "R13 ignored code LO", loOut, 32'h1357_9BDF);

    // R13 restart while busy
    @(negedge clk); opValid = 1; opCode = 3'd2; opA = 32'd99; opB = 32'd4;
    @(negedge clk); opValid = 0;
    repeat (4) @(negedge clk);
    runOp(3'd1, 32'd9, 32'd11, "R13 restart");

    // constrained random
    for (int k = 0; k < 60; k++) begin
      rop = 3'($urandom % 4);
      ra = $urandom >> ($urandom % 32);
      if ($urandom % 2) ra = -ra;
      rb = $urandom >> ($urandom % 32);
      if ($urandom % 8 == 0) rb = 32'd0;
      runOp(rop, ra, rb, "R2 R3 R4 R5 R6 R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule